// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor built around a single accumulator. It runs instructions in separate register-transfer steps. First it moves the program counter into an address register and reads memory into a data register. It then copies that word into an instruction register and decodes it. When the instruction needs an operand, the execute steps that follow take it through the same address and data registers. Code and data share one internal memory. A program can therefore read, overwrite or execute any word, and that includes its own instructions.

Each 8-bit word is split into two fields. The high four bits select the operation and the low bits give a memory word address. Programs are placed in memory while the core is held in reset, through a load port that is active only then. Once reset is released, the core starts executing at address 0. It stops on the halt operation, and after that the accumulator result can be read at the outputs.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, and directly after it is released, `halted` is 0 and `acc_out` is 0. The first instruction comes from address 0.
- R2: Each word is split into an operation code, in bits 7:4, and an operand address, in bits 3:0. Code 0x5 (load) copies the word at the operand address into the accumulator.
- R3: Code 0x1 (add) sets the accumulator to accumulator plus the word at the operand address, modulo 256.
- R4: Code 0x2 (subtract) sets the accumulator to accumulator minus the word at the operand address, modulo 256.
- R5: Code 0x3 (store) writes the accumulator into the memory word at the operand address. A later load from that address returns the stored value.
- R6: Code 0x0 (halt) sets `halted`. After that, `halted` and `acc_out` stay constant until reset.
- R7: Codes 0x4 and 0x6 to 0xF do nothing. The accumulator keeps its value and execution moves on to the next address.
- R8: The program counter advances by one on every fetch and wraps from address 15 to address 0. An instruction that a store has written is executed when the counter reaches its address.
- R9: Counted in clock edges after reset is released, a halt or no-op instruction takes 4 cycles, a store takes 6 cycles, and a load, add or subtract takes 7 cycles.
- R10: The load port writes memory only while reset is asserted. While the core runs, a write through the load port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also enables the load port |
| ld_we | input | 1 | Load port write strobe (honoured only in reset) |
| ld_addr | input | ADDR_W | Load port word address |
| ld_data | input | DATA_W | Load port write data |
| halted | output | 1 | High once a halt instruction has executed |
| acc_out | output | DATA_W | Accumulator contents |

## Verification
The bench uses the default build: 4-bit addresses, which give 16 words, with 8-bit data. A 16-word memory is small enough for one program to run through every address. That program wraps the program counter and then runs a halt that it wrote into word 0 earlier in the same run. The 8-bit data width means a single add or subtract is enough to push the result past 255 or below 0. Because every instruction class has a fixed cycle count, the bench checks the exact cycle at which `halted` rises for each program.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [2:0] {
      ST_FETCH_ADDR,
      ST_FETCH_READ,
      ST_FETCH_CIR,
      ST_DECODE,
      ST_EXEC_ADDR,
      ST_EXEC_READ,
      ST_EXEC_WB,
      ST_HALTED
   } cpu_state_e;

   typedef enum logic [1:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB
   } alu_op_e;

   localparam logic [OPC_W-1:0] OP_HALT  = 4'h0;
   localparam logic [OPC_W-1:0] OP_ADD   = 4'h1;
   localparam logic [OPC_W-1:0] OP_SUB   = 4'h2;
   localparam logic [OPC_W-1:0] OP_STORE = 4'h3;
   localparam logic [OPC_W-1:0] OP_LOAD  = 4'h5;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (we && (waddr == ADDR_W'(gi))) word_q[gi] <= wdata;
      end
   end

   assign rdata = word_q[raddr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         default: y = b;
      endcase
   end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output cpu_state_e       state,
   output logic             mar_from_pc,
   output logic             mar_from_opnd,
   output logic             mdr_from_mem,
   output logic             mdr_from_acc,
   output logic             cir_load,
   output logic             pc_inc,
   output logic             acc_load,
   output logic             mem_we,
   output alu_op_e          alu_op
);
   cpu_state_e state_q, state_d;
   logic       is_store, has_operand;

   assign is_store    = (opcode == OP_STORE);
   assign has_operand = (opcode == OP_LOAD) || (opcode == OP_ADD) ||
                        (opcode == OP_SUB)  || is_store;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_FETCH_ADDR: state_d = ST_FETCH_READ;
         ST_FETCH_READ: state_d = ST_FETCH_CIR;
         ST_FETCH_CIR:  state_d = ST_DECODE;
         ST_DECODE: begin
            if (opcode == OP_HALT) state_d = ST_HALTED;
            else if (has_operand)  state_d = ST_EXEC_ADDR;
            else                   state_d = ST_FETCH_ADDR;
         end
         ST_EXEC_ADDR:  state_d = is_store ? ST_EXEC_WB : ST_EXEC_READ;
         ST_EXEC_READ:  state_d = ST_EXEC_WB;
         ST_EXEC_WB:    state_d = ST_FETCH_ADDR;
         default:       state_d = ST_HALTED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_FETCH_ADDR;
      else        state_q <= state_d;
   end

   assign state         = state_q;
   assign mar_from_pc   = (state_q == ST_FETCH_ADDR);
   assign pc_inc        = (state_q == ST_FETCH_READ);
   assign mdr_from_mem  = (state_q == ST_FETCH_READ) || (state_q == ST_EXEC_READ);
   assign cir_load      = (state_q == ST_FETCH_CIR);
   assign mar_from_opnd = (state_q == ST_EXEC_ADDR);
   assign mdr_from_acc  = (state_q == ST_EXEC_ADDR) && is_store;
   assign acc_load      = (state_q == ST_EXEC_WB) && !is_store;
   assign mem_we        = (state_q == ST_EXEC_WB) && is_store;

   always_comb begin
      case (opcode)
         OP_ADD:  alu_op = ALU_ADD;
         OP_SUB:  alu_op = ALU_SUB;
         default: alu_op = ALU_PASS;
      endcase
   end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = OPC_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic              halted,
   output logic [DATA_W-1:0] acc_out
);
   if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr_w
      $error("acc_cpu: ADDR_W must lie in 2..8");
   end
   if (DATA_W != OPC_W + ADDR_W) begin : g_bad_data_w
      $error("acc_cpu: DATA_W must equal opcode width plus ADDR_W");
   end

   cpu_state_e        state;
   logic              mar_from_pc, mar_from_opnd, mdr_from_mem, mdr_from_acc;
   logic              cir_load, pc_inc, acc_load, core_we;
   alu_op_e           alu_op;
   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] mdr_q, cir_q, acc_q;
   logic [DATA_W-1:0] mem_rdata, alu_y;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;
   logic [OPC_W-1:0]  opcode;
   logic [ADDR_W-1:0] operand;

   assign opcode  = cir_q[DATA_W-1 -: OPC_W];
   assign operand = cir_q[ADDR_W-1:0];

   acc_cpu_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .opcode        (opcode),
      .state         (state),
      .mar_from_pc   (mar_from_pc),
      .mar_from_opnd (mar_from_opnd),
      .mdr_from_mem  (mdr_from_mem),
      .mdr_from_acc  (mdr_from_acc),
      .cir_load      (cir_load),
      .pc_inc        (pc_inc),
      .acc_load      (acc_load),
      .mem_we        (core_we),
      .alu_op        (alu_op)
   );

   // Load port owns the write side only while reset holds the core.
   assign mem_we    = rst_n ? core_we : ld_we;
   assign mem_waddr = rst_n ? mar_q   : ld_addr;
   assign mem_wdata = rst_n ? mdr_q   : ld_data;

   acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mar_q),
      .rdata (mem_rdata)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .op (alu_op),
      .a  (acc_q),
      .b  (mdr_q),
      .y  (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         cir_q <= '0;
         acc_q <= '0;
      end else begin
         if (pc_inc)             pc_q  <= pc_q + 1'b1;
         if (mar_from_pc)        mar_q <= pc_q;
         else if (mar_from_opnd) mar_q <= operand;
         if (mdr_from_mem)       mdr_q <= mem_rdata;
         else if (mdr_from_acc)  mdr_q <= acc_q;
         if (cir_load)           cir_q <= mdr_q;
         if (acc_load)           acc_q <= alu_y;
      end
   end

   assign halted  = (state == ST_HALTED);
   assign acc_out = acc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic [DATA_W-1:0] acc_out,
   input cpu_state_e        state,
   input logic [ADDR_W-1:0] pc_q,
   input logic [ADDR_W-1:0] mar_q,
   input logic [DATA_W-1:0] mdr_q,
   input logic [DATA_W-1:0] cir_q
);
   p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_acc_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(acc_out));

   p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH_READ) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

   p_mar_from_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH_ADDR) |=> (mar_q == $past(pc_q)));

   p_cir_from_mdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH_CIR) |=> (cir_q == $past(mdr_q)));

   p_acc_only_in_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_out) |-> ($past(state) == ST_EXEC_WB));

   p_store_mdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC_ADDR && cir_q[DATA_W-1 -: OPC_W] == OP_STORE)
      |=> (mdr_q == $past(acc_out)));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .halted  (halted),
   .acc_out (acc_out),
   .state   (state),
   .pc_q    (pc_q),
   .mar_q   (mar_q),
   .mdr_q   (mdr_q),
   .cir_q   (cir_q)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic          halted;
   logic [DW-1:0] acc_out;

   int vectors = 0;
   int fails   = 0;
   logic [DW-1:0] img [16];

   always #2.5 clk = ~clk;

   acc_cpu #(.ADDR_W(AW)) u_acc_cpu (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
      .ld_data(ld_data), .halted(halted), .acc_out(acc_out)
   );

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_img();
      for (int i = 0; i < 16; i++) img[i] = 8'hF0;
   endtask

   task automatic load_img();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = AW'(i); ld_data = img[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   // Release reset and count edges until halted; returns edge count.
   task automatic run(output int n);
      @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      while (n < 400) begin
         @(posedge clk); #1;
         n++;
         if (halted) break;
      end
   endtask

   task automatic t_reset_halt();
      int n;
      clear_img();
      img[0] = 8'h00;
      load_img();
      check("R1 halted in reset", int'(halted), 0);
      check("R1 acc in reset", int'(acc_out), 0);
      run(n);
      check("R6 halted set", int'(halted), 1);
      check("R9 halt cycles", n, 4);
      check("R1 acc after halt-only", int'(acc_out), 0);
   endtask

   task automatic t_load();
      int n;
      clear_img();
      img[0] = 8'h59; img[1] = 8'h00; img[9] = 8'h3C;
      load_img();
      run(n);
      check("R2 load value", int'(acc_out), 'h3C);
      check("R9 load+halt cycles", n, 11);
      repeat (20) @(posedge clk);
      #1;
      check("R6 still halted", int'(halted), 1);
      check("R6 acc held", int'(acc_out), 'h3C);
   endtask

   task automatic t_add_wrap();
      int n;
      clear_img();
      img[0] = 8'h58; img[1] = 8'h19; img[2] = 8'h00;
      img[8] = 8'hF0; img[9] = 8'h25;
      load_img();
      run(n);
      check("R3 add wraps", int'(acc_out), 'h15);
      check("R9 add cycles", n, 18);
   endtask

   task automatic t_sub_wrap();
      int n;
      clear_img();
      img[0] = 8'h58; img[1] = 8'h29; img[2] = 8'h00;
      img[8] = 8'h10; img[9] = 8'h30;
      load_img();
      run(n);
      check("R4 sub wraps", int'(acc_out), 'hE0);
   endtask

   task automatic t_store();
      int n;
      clear_img();
      img[0] = 8'h5A; img[1] = 8'h3B; img[2] = 8'h5C; img[3] = 8'h5B;
      img[4] = 8'h00;
      img[10] = 8'h5A; img[11] = 8'h77; img[12] = 8'h11;
      load_img();
      run(n);
      check("R5 stored value reloaded", int'(acc_out), 'h5A);
      check("R9 store cycles", n, 31);
   endtask

   task automatic t_nop();
      int n;
      clear_img();
      img[0] = 8'h58; img[1] = 8'h4F; img[2] = 8'h9F; img[3] = 8'hF3;
      img[4] = 8'h00; img[8] = 8'h21;
      load_img();
      run(n);
      check("R7 nops leave acc", int'(acc_out), 'h21);
      check("R7 R9 nop cycles", n, 23);
   endtask

   task automatic t_pc_wrap();
      int n;
      clear_img();
      img[0] = 8'h5F; img[1] = 8'h2F; img[2] = 8'h30; img[3] = 8'h5E;
      img[14] = 8'h6A; img[15] = 8'h47;
      load_img();
      run(n);
      check("R8 wrap reaches stored halt", int'(halted), 1);
      check("R8 acc after wrap", int'(acc_out), 'h6A);
      check("R8 wrap cycles", n, 79);
   endtask

   task automatic t_ld_ignored();
      int n;
      clear_img();
      img[0] = 8'h40; img[1] = 8'h40; img[2] = 8'h59; img[3] = 8'h00;
      img[9] = 8'h3C;
      load_img();
      @(negedge clk);
      rst_n = 1'b1;
      ld_we = 1'b1; ld_addr = 4'd9; ld_data = 8'hEE;
      n = 1;
      while (n < 400) begin
         @(posedge clk); #1;
         n++;
         if (halted) break;
      end
      ld_we = 1'b0;
      check("R10 load port ignored when running", int'(acc_out), 'h3C);
   endtask

   initial begin
      #(5 * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      t_reset_halt();
      t_load();
      t_add_wrap();
      t_sub_wrap();
      t_store();
      t_nop();
      t_pc_wrap();
      t_ld_ignored();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule